// File: doc/BRIEF.md
# MMU access fault checker

This block decides, for a single memory access, whether the access may go ahead once a two-level table walk has returned its descriptors. The access is described by its address, its size (byte, half-word or word), a write flag and an alignment-check enable. The checker looks at the first-level descriptor, the optional second-level page entry and the domain access control word. It reports at most one fault: the first one found in a fixed order of checks.

The checker also prepares the data path for accesses that are allowed to be non-aligned. It turns the memory word fetched for a read so that the addressed byte lands in the low lane. It lowers write addresses to the boundary of the access size. All results are registered and appear one clock after the strobe that marks the descriptors as valid.

Top module: `mmu_fault_chk`

## Requirements
- R1: Results (`res_valid`, `fault_valid`, `fault_type`, `fault_page`, `eff_addr`, `rd_data`) register on a clock edge where `acc_valid` is high and appear one cycle later with `res_valid` high for that one cycle. Without `acc_valid`, `res_valid` is low and all other outputs keep their values whatever the inputs do. Reset clears every output to 0.
- R2: The access size uses 0 for byte, 1 for half-word, and 2 or 3 for word. With `align_chk_en` high, a half-word with `acc_addr[0]`=1 or a word with `acc_addr[1:0]`≠0 gives `fault_type`=1 (alignment) with `fault_page`=0, and no other check is made. Bytes are never misaligned.
- R3: For a read, `rd_data` is `rd_word` rotated right by 8×`acc_addr[1:0]` bits and `eff_addr` is `acc_addr` with bits [1:0] cleared. A word at byte offset 3 of 0xAABBCCDD reads as 0xBBCCDDAA.
- R4: For a write with `align_chk_en` low, `eff_addr` clears bit 0 for a half-word and bits [1:0] for a word, and leaves a byte address unchanged. For a write with `align_chk_en` high, `eff_addr` equals `acc_addr`.
- R5: `l1_desc[1:0]`=00 gives `fault_type`=2 (translation) with `fault_page`=0. `l1_desc[1:0]`=10 marks a section; 01 and 11 mark a page that uses `l2_entry`.
- R6: On the page path, `l2_entry[1:0]`=00 gives `fault_type`=2 with `fault_page`=1.
- R7: The domain index is `l1_desc[8:5]`. Index i selects the 2-bit field `dacr[2i+1:2i]`.
- R8: A selected domain field of 00 or 10 gives `fault_type`=3 (domain). `fault_page` is 1 on the page path and 0 for a section.
- R9: A domain field of 01 (client) checks the permission pair, taken from `l1_desc[11:10]` for a section and from `l2_entry[5:4]` for a page. Pair 00 denies every access, 01 denies writes only, and 10 or 11 allows all. A denial gives `fault_type`=4 (permission) with the section/page qualifier.
- R10: A domain field of 11 (manager) allows the access whatever the permission pair says; `fault_type`=0.
- R11: The checks run in the order alignment, translation (first level, then second level), domain, permission; only the first failing check is reported. `fault_valid` is 1 exactly when `fault_type` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Strobe: descriptors and access attributes are valid |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| align_chk_en | input | 1 | Enables alignment faults |
| l1_desc | input | 32 | First-level descriptor |
| l2_entry | input | 32 | Second-level page entry |
| dacr | input | 32 | Sixteen 2-bit domain fields |
| rd_word | input | 32 | Memory word fetched for a read |
| res_valid | output | 1 | Result strobe, one cycle after `acc_valid` |
| fault_valid | output | 1 | A fault was found |
| fault_type | output | 3 | 0 none, 1 alignment, 2 translation, 3 domain, 4 permission |
| fault_page | output | 1 | 1 for page, 0 for section |
| eff_addr | output | 32 | Address issued to memory |
| rd_data | output | 32 | Rotated read data |

## Verification
On every cycle the bound assertions check these properties:
- the one-cycle result latency;
- that outputs hold while idle;
- that a misaligned access with checking enabled always reports an alignment fault;
- that both kinds of invalid descriptor report a translation fault with the right qualifier;
- that a manager domain on a valid section never faults;
- that the fault flag agrees with the fault code.

Only the bench's scenarios show three things:
- the exact rotated read data and lowered write addresses;
- the client permission pairs for reads and writes;
- the precedence when several faults apply at once, with a scoreboard model run against directed and random accesses.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ALIGN  = 3'd1,
      FLT_XLATE  = 3'd2,
      FLT_DOMAIN = 3'd3,
      FLT_PERM   = 3'd4
   } flt_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   localparam logic [1:0] DOM_NOACC  = 2'b00;
   localparam logic [1:0] DOM_CLIENT = 2'b01;
   localparam logic [1:0] DOM_RSVD   = 2'b10;
   localparam logic [1:0] DOM_MGR    = 2'b11;

   localparam logic [1:0] L1_INVALID = 2'b00;
   localparam logic [1:0] L1_SECTION = 2'b10;
   localparam logic [1:0] L2_INVALID = 2'b00;

   localparam logic [1:0] AP_NONE = 2'b00;
   localparam logic [1:0] AP_RDONLY = 2'b01;

   typedef struct packed {
      flt_e kind;
      logic page;
   } verdict_t;

endpackage

// File: rtl/mfc_align.sv
module mfc_align
   import mmu_fault_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int ROT_IMPL = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              write,
   input  logic              chk_en,
   input  logic [DATA_W-1:0] rd_word,
   output logic              misaligned,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [DATA_W-1:0] rd_rot
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam logic [ADDR_W-1:0] WORD_MASK = ~(ADDR_W'(LANES - 1));
   localparam logic [ADDR_W-1:0] HALF_MASK = ~(ADDR_W'(1));

   logic [OFF_W-1:0] off;
   assign off = addr[OFF_W-1:0];

   always_comb begin
      case (size)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = addr[0];
         default: misaligned = |off;
      endcase
   end

   always_comb begin
      if (!write) begin
         eff_addr = addr & WORD_MASK;
      end else if (chk_en) begin
         eff_addr = addr;
      end else begin
         case (size)
            SZ_BYTE: eff_addr = addr;
            SZ_HALF: eff_addr = addr & HALF_MASK;
            default: eff_addr = addr & WORD_MASK;
         endcase
      end
   end

   generate
      if (ROT_IMPL == 0) begin : g_rot_mux
         logic [DATA_W-1:0] cand [LANES];
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            if (k == 0) begin : g_k0
               assign cand[k] = rd_word;
            end else begin : g_kn
               assign cand[k] = {rd_word[8*k-1:0], rd_word[DATA_W-1:8*k]};
            end
         end
         assign rd_rot = cand[off];
      end else begin : g_rot_shift
         logic [2*DATA_W-1:0] dbl;
         logic [2*DATA_W-1:0] shifted;
         assign dbl     = {rd_word, rd_word};
         assign shifted = dbl >> {off, 3'b000};
         assign rd_rot  = shifted[DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mfc_dom_sel.sv
module mfc_dom_sel #(
   parameter int NUM_DOM = 16,
   parameter int IDX_W   = $clog2(NUM_DOM)
) (
   input  logic [2*NUM_DOM-1:0] dacr,
   input  logic [IDX_W-1:0]     idx,
   output logic [1:0]           field
);

   logic [1:0] fld [NUM_DOM];

   generate
      for (genvar g = 0; g < NUM_DOM; g++) begin : g_fld
         assign fld[g] = dacr[2*g +: 2];
      end
   endgenerate

   assign field = fld[idx];

endmodule

// File: rtl/mfc_perm.sv
module mfc_perm
   import mmu_fault_pkg::*;
(
   input  logic [1:0] ap,
   input  logic       write,
   output logic       deny
);

   always_comb begin
      case (ap)
         AP_NONE:   deny = 1'b1;
         AP_RDONLY: deny = write;
         default:   deny = 1'b0;
      endcase
   end

endmodule

// File: rtl/mmu_fault_chk.sv
module mmu_fault_chk
   import mmu_fault_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int DESC_W    = 32,
   parameter int NUM_DOM   = 16,
   parameter int DOM_LSB   = 5,
   parameter int L1_AP_LSB = 10,
   parameter int L2_AP_LSB = 4,
   parameter int ROT_IMPL  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [1:0]           acc_size,
   input  logic                 acc_write,
   input  logic                 align_chk_en,
   input  logic [DESC_W-1:0]    l1_desc,
   input  logic [DESC_W-1:0]    l2_entry,
   input  logic [2*NUM_DOM-1:0] dacr,
   input  logic [DATA_W-1:0]    rd_word,
   output logic                 res_valid,
   output logic                 fault_valid,
   output logic [2:0]           fault_type,
   output logic                 fault_page,
   output logic [ADDR_W-1:0]    eff_addr,
   output logic [DATA_W-1:0]    rd_data
);

   localparam int IDX_W = $clog2(NUM_DOM);
   localparam int LANES = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_data
         $error("mmu_fault_chk: DATA_W must be a power-of-two number of bytes, at least two");
      end
      if ((NUM_DOM & (NUM_DOM - 1)) != 0 || NUM_DOM < 2) begin : g_bad_dom
         $error("mmu_fault_chk: NUM_DOM must be a power of two");
      end
      if (DOM_LSB + IDX_W > DESC_W || L1_AP_LSB + 2 > DESC_W || L2_AP_LSB + 2 > DESC_W) begin : g_bad_fields
         $error("mmu_fault_chk: descriptor field outside DESC_W");
      end
      if (ADDR_W < $clog2(LANES) + 1) begin : g_bad_addr
         $error("mmu_fault_chk: ADDR_W too small");
      end
      if (ROT_IMPL != 0 && ROT_IMPL != 1) begin : g_bad_rot
         $error("mmu_fault_chk: ROT_IMPL must be 0 or 1");
      end
   endgenerate

   logic              mis;
   logic [ADDR_W-1:0] eff_nxt;
   logic [DATA_W-1:0] rot_nxt;
   logic [1:0]        dom_field;
   logic [1:0]        ap_sel;
   logic              deny;
   logic              on_page;
   verdict_t          vd;

   mfc_align #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .ROT_IMPL(ROT_IMPL)
   ) u_align (
      .addr      (acc_addr),
      .size      (acc_size),
      .write     (acc_write),
      .chk_en    (align_chk_en),
      .rd_word   (rd_word),
      .misaligned(mis),
      .eff_addr  (eff_nxt),
      .rd_rot    (rot_nxt)
   );

   mfc_dom_sel #(
      .NUM_DOM(NUM_DOM),
      .IDX_W  (IDX_W)
   ) u_dom (
      .dacr (dacr),
      .idx  (l1_desc[DOM_LSB +: IDX_W]),
      .field(dom_field)
   );

   assign on_page = (l1_desc[1:0] != L1_SECTION);
   assign ap_sel  = on_page ? l2_entry[L2_AP_LSB +: 2] : l1_desc[L1_AP_LSB +: 2];

   mfc_perm u_perm (
      .ap   (ap_sel),
      .write(acc_write),
      .deny (deny)
   );

   always_comb begin
      vd.kind = FLT_NONE;
      vd.page = 1'b0;
      if (align_chk_en && mis) begin
         vd.kind = FLT_ALIGN;
      end else if (l1_desc[1:0] == L1_INVALID) begin
         vd.kind = FLT_XLATE;
      end else if (on_page && l2_entry[1:0] == L2_INVALID) begin
         vd.kind = FLT_XLATE;
         vd.page = 1'b1;
      end else if (dom_field == DOM_NOACC || dom_field == DOM_RSVD) begin
         vd.kind = FLT_DOMAIN;
         vd.page = on_page;
      end else if (dom_field == DOM_CLIENT && deny) begin
         vd.kind = FLT_PERM;
         vd.page = on_page;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         fault_valid <= 1'b0;
         fault_type  <= 3'd0;
         fault_page  <= 1'b0;
         eff_addr    <= '0;
         rd_data     <= '0;
      end else begin
         res_valid <= acc_valid;
         if (acc_valid) begin
            fault_valid <= (vd.kind != FLT_NONE);
            fault_type  <= vd.kind;
            fault_page  <= vd.page;
            eff_addr    <= eff_nxt;
            rd_data     <= rot_nxt;
         end
      end
   end

endmodule

// File: rtl/mmu_fault_chk_sva.sv
module mmu_fault_chk_sva #(
   parameter int ADDR_W  = 32,
   parameter int DESC_W  = 32,
   parameter int NUM_DOM = 16,
   parameter int DOM_LSB = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_valid,
   input logic [ADDR_W-1:0]    acc_addr,
   input logic [1:0]           acc_size,
   input logic                 align_chk_en,
   input logic [DESC_W-1:0]    l1_desc,
   input logic [DESC_W-1:0]    l2_entry,
   input logic [2*NUM_DOM-1:0] dacr,
   input logic                 res_valid,
   input logic                 fault_valid,
   input logic [2:0]           fault_type,
   input logic                 fault_page
);

   localparam int IDX_W = $clog2(NUM_DOM);

   logic             mis_c;
   logic             aligned_ok;
   logic [IDX_W-1:0] idx_c;
   logic [1:0]       dom_c;

   assign mis_c      = (acc_size == 2'd1 && acc_addr[0]) || (acc_size[1] && acc_addr[1:0] != 2'b00);
   assign aligned_ok = !(align_chk_en && mis_c);
   assign idx_c      = l1_desc[DOM_LSB +: IDX_W];
   assign dom_c      = dacr[{idx_c, 1'b0} +: 2];

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid);

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!res_valid && $stable(fault_type) && $stable(fault_page) && $stable(fault_valid)));

   assert_align_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && align_chk_en && mis_c) |=> (fault_type == 3'd1 && !fault_page));

   assert_sect_xlate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && aligned_ok && l1_desc[1:0] == 2'b00) |=> (fault_type == 3'd2 && !fault_page));

   assert_page_xlate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && aligned_ok && l1_desc[1:0] != 2'b00 && l1_desc[1:0] != 2'b10 && l2_entry[1:0] == 2'b00)
      |=> (fault_type == 3'd2 && fault_page));

   assert_manager_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && aligned_ok && l1_desc[1:0] == 2'b10 && dom_c == 2'b11) |=> (fault_type == 3'd0));

   assert_flag_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid == (fault_type != 3'd0));

   assert_code_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_type <= 3'd4);

endmodule

bind mmu_fault_chk mmu_fault_chk_sva #(
   .ADDR_W (ADDR_W),
   .DESC_W (DESC_W),
   .NUM_DOM(NUM_DOM),
   .DOM_LSB(DOM_LSB)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_addr    (acc_addr),
   .acc_size    (acc_size),
   .align_chk_en(align_chk_en),
   .l1_desc     (l1_desc),
   .l2_entry    (l2_entry),
   .dacr        (dacr),
   .res_valid   (res_valid),
   .fault_valid (fault_valid),
   .fault_type  (fault_type),
   .fault_page  (fault_page)
);

// File: tb/mmu_fault_chk_tb_top.sv
module mmu_fault_chk_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_write = 1'b0;
   logic        align_chk_en = 1'b0;
   logic [31:0] l1_desc = '0;
   logic [31:0] l2_entry = '0;
   logic [31:0] dacr = '0;
   logic [31:0] rd_word = '0;
   logic        res_valid;
   logic        fault_valid;
   logic [2:0]  fault_type;
   logic        fault_page;
   logic [31:0] eff_addr;
   logic [31:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   mmu_fault_chk dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .acc_addr    (acc_addr),
      .acc_size    (acc_size),
      .acc_write   (acc_write),
      .align_chk_en(align_chk_en),
      .l1_desc     (l1_desc),
      .l2_entry    (l2_entry),
      .dacr        (dacr),
      .rd_word     (rd_word),
      .res_valid   (res_valid),
      .fault_valid (fault_valid),
      .fault_type  (fault_type),
      .fault_page  (fault_page),
      .eff_addr    (eff_addr),
      .rd_data     (rd_data)
   );

   typedef struct {
      logic [2:0]  ftype;
      logic        fpage;
      logic [31:0] eff;
      logic [31:0] rdata;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   function automatic logic [31:0] mk_l1(logic [1:0] ty, logic [3:0] dom, logic [1:0] ap);
      return {20'h0, ap, 1'b0, dom, 3'b000, ty};
   endfunction

   function automatic logic [31:0] mk_l2(logic [1:0] ty, logic [1:0] ap);
      return {26'h0, ap, 2'b00, ty};
   endfunction

   function automatic logic [31:0] set_dom(logic [31:0] base, int idx, logic [1:0] val);
      logic [31:0] r = base;
      r[2*idx]   = val[0];
      r[2*idx+1] = val[1];
      return r;
   endfunction

   function automatic exp_t model(logic [31:0] a, logic [1:0] sz, logic wr, logic chk,
                                  logic [31:0] l1, logic [31:0] l2, logic [31:0] dc, logic [31:0] rd);
      exp_t e;
      logic mis;
      logic pg;
      logic [1:0] dom;
      logic [1:0] ap;
      case (sz)
         2'd0:    mis = 1'b0;
         2'd1:    mis = a[0];
         default: mis = (a[1:0] != 2'b00);
      endcase
      case (a[1:0])
         2'd0: e.rdata = rd;
         2'd1: e.rdata = {rd[7:0],  rd[31:8]};
         2'd2: e.rdata = {rd[15:0], rd[31:16]};
         default: e.rdata = {rd[23:0], rd[31:24]};
      endcase
      if (!wr)       e.eff = {a[31:2], 2'b00};
      else if (chk)  e.eff = a;
      else if (sz == 2'd0) e.eff = a;
      else if (sz == 2'd1) e.eff = {a[31:1], 1'b0};
      else           e.eff = {a[31:2], 2'b00};
      e.ftype = 3'd0;
      e.fpage = 1'b0;
      pg  = (l1[1:0] != 2'b10);
      dom = 2'((dc >> (2 * int'(l1[8:5]))) & 32'h3);
      ap  = pg ? l2[5:4] : l1[11:10];
      if (chk && mis) e.ftype = 3'd1;
      else if (l1[1:0] == 2'b00) e.ftype = 3'd2;
      else if (pg && l2[1:0] == 2'b00) begin e.ftype = 3'd2; e.fpage = 1'b1; end
      else if (dom == 2'b00 || dom == 2'b10) begin e.ftype = 3'd3; e.fpage = pg; end
      else if (dom == 2'b01 && (ap == 2'b00 || (ap == 2'b01 && wr))) begin e.ftype = 3'd4; e.fpage = pg; end
      e.tag = "";
      return e;
   endfunction

   task automatic drive(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic chk, input logic [31:0] l1, input logic [31:0] l2,
                        input logic [31:0] dc, input logic [31:0] rd);
      exp_t e;
      @(negedge clk);
      acc_addr = a; acc_size = sz; acc_write = wr; align_chk_en = chk;
      l1_desc = l1; l2_entry = l2; dacr = dc; rd_word = rd;
      acc_valid = 1'b1;
      e = model(a, sz, wr, chk, l1, l2, dc, rd);
      e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk);
      #1 acc_valid = 1'b0;
   endtask

   // monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         exp_t e;
         n_tests++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected result R1: got res_valid=1 expected none");
         end else begin
            e = sb_q.pop_front();
            if (fault_type !== e.ftype || fault_page !== e.fpage || fault_valid !== (e.ftype != 3'd0)
                || eff_addr !== e.eff || rd_data !== e.rdata) begin
               n_fail++;
               $display("FAIL %s: got type=%0d page=%0d fv=%0d eff=%h rd=%h expected type=%0d page=%0d fv=%0d eff=%h rd=%h",
                        e.tag, fault_type, fault_page, fault_valid, eff_addr, rd_data,
                        e.ftype, e.fpage, (e.ftype != 3'd0), e.eff, e.rdata);
            end
         end
      end
   end

   task automatic check(input string tag, input logic ok, input string got, input string expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %s expected %s", tag, got, expv);
      end
   endtask

   localparam logic [31:0] ALL_MGR = 32'hFFFF_FFFF;
   localparam logic [31:0] ALL_CLI = 32'h5555_5555;

   initial begin
      logic [31:0] dc;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", res_valid === 1'b0 && fault_valid === 1'b0 && fault_type === 3'd0 &&
            fault_page === 1'b0 && eff_addr === 32'h0 && rd_data === 32'h0,
            $sformatf("rv=%0d ft=%0d eff=%h rd=%h", res_valid, fault_type, eff_addr, rd_data), "all zero");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: read rotation
      drive("R3 word read off3", 32'h1000_0003, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'hAABB_CCDD);
      drive("R3 half read off1", 32'h1000_0001, 2'd1, 1'b0, 1'b0, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'h1122_3344);
      drive("R3 byte read off2", 32'h1000_0006, 2'd0, 1'b0, 1'b1, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'h1122_3344);
      // R4: write address lowering
      drive("R4 word write off2", 32'h2000_0012, 2'd2, 1'b1, 1'b0, mk_l1(2'b10, 4'd1, 2'b11), 32'h0, ALL_MGR, 32'h0);
      drive("R4 half write off3", 32'h2000_0013, 2'd1, 1'b1, 1'b0, mk_l1(2'b10, 4'd1, 2'b11), 32'h0, ALL_MGR, 32'h0);
      drive("R4 byte write chk on", 32'h2000_0013, 2'd0, 1'b1, 1'b1, mk_l1(2'b10, 4'd1, 2'b11), 32'h0, ALL_MGR, 32'h0);
      drive("R4 byte write chk off", 32'h2000_0011, 2'd0, 1'b1, 1'b0, mk_l1(2'b10, 4'd1, 2'b11), 32'h0, ALL_MGR, 32'h0);
      // R2 / R11: alignment first, even with invalid descriptor
      drive("R2 word misaligned R11", 32'h3000_0001, 2'd2, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0);
      drive("R2 half misaligned", 32'h3000_0005, 2'd1, 1'b1, 1'b1, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'h0);
      drive("R2 size3 misaligned", 32'h3000_0002, 2'd3, 1'b0, 1'b1, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'h0);
      drive("R2 half aligned", 32'h3000_0006, 2'd1, 1'b0, 1'b1, mk_l1(2'b10, 4'd0, 2'b11), 32'h0, ALL_MGR, 32'h0);
      // R5 / R6 translation
      drive("R5 l1 invalid R11", 32'h4000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b00, 4'd2, 2'b00), 32'h0, 32'h0, 32'h0);
      drive("R6 l2 invalid coarse", 32'h4000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b01, 4'd2, 2'b11), mk_l2(2'b00, 2'b11), ALL_MGR, 32'h0);
      drive("R6 l2 invalid fine", 32'h4000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b11, 4'd2, 2'b11), mk_l2(2'b00, 2'b11), ALL_MGR, 32'h0);
      // R8 domain
      dc = set_dom(ALL_MGR, 7, 2'b00);
      drive("R8 section no-access", 32'h5000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd7, 2'b11), 32'h0, dc, 32'h0);
      dc = set_dom(ALL_MGR, 15, 2'b10);
      drive("R8 page reserved", 32'h5000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b01, 4'd15, 2'b11), mk_l2(2'b10, 2'b11), dc, 32'h0);
      // R7 domain index selection
      dc = set_dom(32'h0, 12, 2'b11);
      drive("R7 idx12 manager", 32'h6000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd12, 2'b00), 32'h0, dc, 32'h0);
      drive("R7 idx11 no-access", 32'h6000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd11, 2'b00), 32'h0, dc, 32'h0);
      // R9 client permission
      drive("R9 section ap00 read", 32'h7000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd3, 2'b00), 32'h0, ALL_CLI, 32'h0);
      drive("R9 section ap01 write", 32'h7000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b10, 4'd3, 2'b01), 32'h0, ALL_CLI, 32'h0);
      drive("R9 section ap01 read", 32'h7000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd3, 2'b01), 32'h0, ALL_CLI, 32'h0);
      drive("R9 section ap10 write", 32'h7000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b10, 4'd3, 2'b10), 32'h0, ALL_CLI, 32'h0);
      drive("R9 page ap01 write", 32'h7000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b01, 4'd3, 2'b11), mk_l2(2'b10, 2'b01), ALL_CLI, 32'h0);
      drive("R9 page ap11 write", 32'h7000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b01, 4'd3, 2'b00), mk_l2(2'b10, 2'b11), ALL_CLI, 32'h0);
      // R10 manager ignores permission
      drive("R10 manager ap00 write", 32'h8000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b10, 4'd9, 2'b00), 32'h0, ALL_MGR, 32'h0);
      drive("R10 manager page ap00", 32'h8000_0000, 2'd2, 1'b1, 1'b0, mk_l1(2'b01, 4'd9, 2'b11), mk_l2(2'b10, 2'b00), ALL_MGR, 32'h0);
      // R11 translation beats domain
      drive("R11 l2 invalid over domain", 32'h9000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b01, 4'd0, 2'b00), mk_l2(2'b00, 2'b00), 32'h0, 32'h0);

      // R1: idle cycles ignore input changes
      dc = set_dom(ALL_MGR, 4, 2'b10);
      drive("R8 idle setup", 32'hA000_0000, 2'd2, 1'b0, 1'b0, mk_l1(2'b10, 4'd4, 2'b11), 32'h0, dc, 32'hDEAD_BEEF);
      @(negedge clk);
      l1_desc = 32'h0; acc_addr = 32'hFFFF_FFFF; rd_word = 32'h0; align_chk_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle hold", res_valid === 1'b0 && fault_type === 3'd3 && fault_page === 1'b0 &&
            eff_addr === 32'hA000_0000 && rd_data === 32'hDEAD_BEEF,
            $sformatf("rv=%0d ft=%0d eff=%h rd=%h", res_valid, fault_type, eff_addr, rd_data),
            "rv=0 ft=3 eff=a0000000 rd=deadbeef");

      // R11: mixed random accesses against the model
      for (int i = 0; i < 80; i++) begin
         drive("R11 random", $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
               mk_l1(2'($urandom), 4'($urandom), 2'($urandom)), mk_l2(2'($urandom), 2'($urandom)),
               $urandom, $urandom);
      end

      repeat (4) @(negedge clk);
      check("R1 all results seen", sb_q.size() == 0, $sformatf("%0d pending", sb_q.size()), "0 pending");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R1: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule